// File: doc/BRIEF.md
# Interrupt and Exception Priority Arbiter

This block sits at the point where a processor core decides, between two instructions, which pending event it will service next. Six sources can request service: a debug fault, a general fault (with its own vector), a software trap from an explicit trap instruction (with its own vector), a debug trap, a non-maskable interrupt pin and a maskable interrupt pin (with its own vector). On each cycle in which the core raises the instruction-boundary strobe, the arbiter selects exactly one winner and reports it on the following cycle as a one-cycle take pulse. The pulse comes with the 8-bit vector and a class tag that tells fault, trap and interrupt apart.

Exception requests are presented only at the boundary. When they lose, they are simply dropped, because the instruction that raised them will raise them again when it re-executes. The non-maskable pin is edge-captured into a pending latch, so a losing request waits for a later boundary. After it is delivered, the pin stays blocked until the core signals return-from-interrupt. The maskable pin is level-sampled, gated by the interrupt-enable flag, and is never stored.

Top module: `irq_exc_arbiter`

## Requirements
- R1: While reset is asserted, take_o is 0, vec_o is 0 and class_o is 0; no NMI is pending or blocked after reset.
- R2: A request is considered only in a cycle where boundary_i is 1. The result appears one clock later as take_o=1 for one cycle. In every cycle without a take, vec_o and class_o are 0.
- R3: Among simultaneous eligible requests, the winner follows the order: debug fault, general fault, software trap, debug trap, NMI, maskable interrupt (highest first).
- R4: Class encoding on class_o: 2'b01 fault, 2'b10 trap, 2'b11 interrupt. Each source reports as follows:
  - debug fault: vector 1, class fault.
  - general fault: vector fault_vec_i, class fault.
  - software trap: vector swi_vec_i, class trap.
  - debug trap: vector 1, class trap.
  - NMI: vector 2, class interrupt.
  - maskable interrupt: vector intr_vec_i, class interrupt.
- R5: A losing exception request is discarded: if it is withdrawn, a later boundary does not deliver it.
- R6: A losing NMI request stays pending and is delivered at a later boundary where nothing of higher priority is eligible.
- R7: The maskable interrupt is ignored while if_flag_i is 0. The NMI is delivered regardless of if_flag_i.
- R8: After an NMI is delivered, no further NMI is delivered until an iret_i pulse. Any number of rising edges arriving while blocked collapse into one pending NMI, which is delivered after the iret_i pulse.
- R9: The NMI pin is edge-sensitive: a pin held high yields exactly one delivery.
- R10: The maskable interrupt is not latched: if intr_i falls before a boundary, no delivery results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe; events accepted in this cycle |
| dbg_fault_i | input | 1 | Debug fault request |
| fault_req_i | input | 1 | General fault request |
| fault_vec_i | input | 8 | Vector of the general fault |
| swi_req_i | input | 1 | Software trap request |
| swi_vec_i | input | 8 | Vector of the software trap |
| dbg_trap_i | input | 1 | Debug trap request |
| nmi_i | input | 1 | Non-maskable interrupt pin (edge-captured) |
| intr_i | input | 1 | Maskable interrupt pin (level) |
| intr_vec_i | input | 8 | Vector supplied with the maskable interrupt |
| if_flag_i | input | 1 | Interrupt-enable flag |
| iret_i | input | 1 | Return-from-interrupt pulse; releases the NMI block |
| take_o | output | 1 | One-cycle delivery strobe |
| vec_o | output | 8 | Vector of the delivered event |
| class_o | output | 2 | Class of the delivered event |

## Verification
The hardest state to reach is a blocked NMI with a further request already latched behind it. The stimulus first delivers one NMI. It then pulses the pin twice with boundaries in between, which must produce nothing, and only then issues iret_i. Exactly one more delivery must follow. A second difficult case is an NMI whose edge lands in the same cycle as a higher-priority fault; the bench checks that this NMI surfaces at the next empty boundary. A behavioural model tracks pending and blocked state on every clock, and a randomised phase then mixes all sources with sparse iret pulses.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'b00,
      CLS_FAULT = 2'b01,
      CLS_TRAP  = 2'b10,
      CLS_INTR  = 2'b11
   } ev_class_e;

   // source slots, index 0 is the highest priority
   localparam int SRC_DBG_FAULT = 0;
   localparam int SRC_FAULT     = 1;
   localparam int SRC_SWI       = 2;
   localparam int SRC_DBG_TRAP  = 3;
   localparam int SRC_NMI       = 4;
   localparam int SRC_INTR      = 5;
   localparam int NUM_SRC       = 6;

   function automatic ev_class_e src_class(input int idx);
      if (idx <= SRC_FAULT)        return CLS_FAULT;
      else if (idx <= SRC_DBG_TRAP) return CLS_TRAP;
      else                          return CLS_INTR;
   endfunction

endpackage

// File: rtl/prio_encoder.sv
module prio_encoder #(
   parameter int N = 6
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   logic found;

   always_comb begin
      grant_o = '0;
      found   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
      any_o = found;
   end
endmodule

// File: rtl/nmi_tracker.sv
module nmi_tracker #(
   parameter bit EDGE_MODE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic iret_i,
   input  logic win_i,
   output logic ready_o
);
   logic set_req;
   logic pend_q;
   logic blk_q;

   generate
      if (EDGE_MODE) begin : g_edge
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_i;
         end
         assign set_req = pin_i & ~pin_q;
      end else begin : g_level
         assign set_req = pin_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         blk_q  <= 1'b0;
      end else begin
         pend_q <= set_req | (pend_q & ~win_i);
         if (win_i)       blk_q <= 1'b1;
         else if (iret_i) blk_q <= 1'b0;
      end
   end

   assign ready_o = pend_q & ~blk_q;

   assert_block_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_q && !iret_i |=> blk_q);
   assert_win_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      win_i |=> !ready_o);
   assert_iret_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iret_i && !win_i && pend_q |=> ready_o);
   assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> pend_q);
endmodule

// File: rtl/irq_exc_arbiter.sv
module irq_exc_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int DBG_VEC  = 1,
   parameter int NMI_VEC  = 2,
   parameter bit NMI_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary_i,
   input  logic             dbg_fault_i,
   input  logic             fault_req_i,
   input  logic [VEC_W-1:0] fault_vec_i,
   input  logic             swi_req_i,
   input  logic [VEC_W-1:0] swi_vec_i,
   input  logic             dbg_trap_i,
   input  logic             nmi_i,
   input  logic             intr_i,
   input  logic [VEC_W-1:0] intr_vec_i,
   input  logic             if_flag_i,
   input  logic             iret_i,
   output logic             take_o,
   output logic [VEC_W-1:0] vec_o,
   output logic [1:0]       class_o
);
   localparam int NSRC = NUM_SRC;

   generate
      if (VEC_W < 2) begin : g_bad_width
         $error("VEC_W must be at least 2");
      end
      if (NMI_VEC >= (1 << VEC_W) || DBG_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("fixed vectors must fit in VEC_W bits");
      end
   endgenerate

   logic [NSRC-1:0]  req;
   logic [NSRC-1:0]  grant;
   logic             any;
   logic             nmi_ready;
   logic [VEC_W-1:0] vtab [NSRC];
   logic [1:0]       ctab [NSRC];
   logic [VEC_W-1:0] vec_sel;
   logic [1:0]       cls_sel;

   assign req[SRC_DBG_FAULT] = dbg_fault_i;
   assign req[SRC_FAULT]     = fault_req_i;
   assign req[SRC_SWI]       = swi_req_i;
   assign req[SRC_DBG_TRAP]  = dbg_trap_i;
   assign req[SRC_NMI]       = nmi_ready;
   assign req[SRC_INTR]      = intr_i & if_flag_i;

   assign vtab[SRC_DBG_FAULT] = VEC_W'(DBG_VEC);
   assign vtab[SRC_FAULT]     = fault_vec_i;
   assign vtab[SRC_SWI]       = swi_vec_i;
   assign vtab[SRC_DBG_TRAP]  = VEC_W'(DBG_VEC);
   assign vtab[SRC_NMI]       = VEC_W'(NMI_VEC);
   assign vtab[SRC_INTR]      = intr_vec_i;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_ctab
         assign ctab[g] = 2'(src_class(g));
      end
   endgenerate

   prio_encoder #(.N(NSRC)) u_prio (
      .req_i   (req),
      .grant_o (grant),
      .any_o   (any)
   );

   nmi_tracker #(.EDGE_MODE(NMI_EDGE)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (nmi_i),
      .iret_i  (iret_i),
      .win_i   (boundary_i & grant[SRC_NMI]),
      .ready_o (nmi_ready)
   );

   always_comb begin
      vec_sel = '0;
      cls_sel = '0;
      for (int i = 0; i < NSRC; i++) begin
         vec_sel = vec_sel | ({VEC_W{grant[i]}} & vtab[i]);
         cls_sel = cls_sel | ({2{grant[i]}} & ctab[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o  <= 1'b0;
         vec_o   <= '0;
         class_o <= CLS_NONE;
      end else if (boundary_i && any) begin
         take_o  <= 1'b1;
         vec_o   <= vec_sel;
         class_o <= cls_sel;
      end else begin
         take_o  <= 1'b0;
         vec_o   <= '0;
         class_o <= CLS_NONE;
      end
   end

   assert_take_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i));
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (vec_o == '0 && class_o == CLS_NONE));
   assert_dbg_fault_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && dbg_fault_i |=> take_o && class_o == CLS_FAULT && vec_o == VEC_W'(DBG_VEC));
   assert_intr_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boundary_i && !if_flag_i && req[SRC_NMI:0] == '0 |=> !take_o);
   assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      take_o && class_o == CLS_INTR && $past(!(intr_i && if_flag_i)) |-> vec_o == VEC_W'(NMI_VEC));
endmodule

// File: tb/irq_exc_arbiter_tb_top.sv
module irq_exc_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boundary_i = 0, dbg_fault_i = 0, fault_req_i = 0, swi_req_i = 0;
   logic       dbg_trap_i = 0, nmi_i = 0, intr_i = 0, if_flag_i = 0, iret_i = 0;
   logic [7:0] fault_vec_i = 0, swi_vec_i = 0, intr_vec_i = 0;
   logic       take_o;
   logic [7:0] vec_o;
   logic [1:0] class_o;

   int   checks = 0;
   int   fails = 0;
   string cur_req = "R1";
   bit   done = 0;

   // reference model state
   bit       m_prev, m_pend, m_blk, rise, won_nmi;
   bit       e_take;
   bit [7:0] e_vec;
   bit [1:0] e_cls;

   always #4 clk = ~clk;

   irq_exc_arbiter dut_i (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
      .dbg_fault_i(dbg_fault_i), .fault_req_i(fault_req_i), .fault_vec_i(fault_vec_i),
      .swi_req_i(swi_req_i), .swi_vec_i(swi_vec_i), .dbg_trap_i(dbg_trap_i),
      .nmi_i(nmi_i), .intr_i(intr_i), .intr_vec_i(intr_vec_i),
      .if_flag_i(if_flag_i), .iret_i(iret_i),
      .take_o(take_o), .vec_o(vec_o), .class_o(class_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 0; m_pend = 0; m_blk = 0;
         e_take = 0; e_vec = 0; e_cls = 0;
      end else begin
         rise = nmi_i && !m_prev;
         m_prev = nmi_i;
         e_take = 0; e_vec = 0; e_cls = 0; won_nmi = 0;
         if (boundary_i) begin
            if (dbg_fault_i)                begin e_take = 1; e_vec = 1;           e_cls = 2'b01; end
            else if (fault_req_i)           begin e_take = 1; e_vec = fault_vec_i; e_cls = 2'b01; end
            else if (swi_req_i)             begin e_take = 1; e_vec = swi_vec_i;   e_cls = 2'b10; end
            else if (dbg_trap_i)            begin e_take = 1; e_vec = 1;           e_cls = 2'b10; end
            else if (m_pend && !m_blk)      begin e_take = 1; e_vec = 2;           e_cls = 2'b11; won_nmi = 1; end
            else if (intr_i && if_flag_i)   begin e_take = 1; e_vec = intr_vec_i;  e_cls = 2'b11; end
         end
         if (won_nmi) begin m_pend = 0; m_blk = 1; end
         else if (iret_i) m_blk = 0;
         if (rise) m_pend = 1;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (!rst_n) begin
            if (take_o !== 1'b0 || vec_o !== 8'h00 || class_o !== 2'b00) begin
               fails++;
               $display("FAIL R1 reset: take=%0b vec=%0h cls=%0b expected 0/0/0", take_o, vec_o, class_o);
            end
         end else if (take_o !== e_take || vec_o !== e_vec || class_o !== e_cls) begin
            fails++;
            $display("FAIL %s: take=%0b vec=%0h cls=%0b expected take=%0b vec=%0h cls=%0b",
                     cur_req, take_o, vec_o, class_o, e_take, e_vec, e_cls);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr();
      boundary_i = 0; dbg_fault_i = 0; fault_req_i = 0; swi_req_i = 0;
      dbg_trap_i = 0; iret_i = 0;
   endtask

   task automatic bnd();
      boundary_i = 1; tick(1); clr(); tick(1);
   endtask

   task automatic expect_take(input string tag, input bit t, input bit [7:0] v, input bit [1:0] c);
      // direct check of the registered output one cycle after the boundary
      checks++;
      if (take_o !== t || vec_o !== v || class_o !== c) begin
         fails++;
         $display("FAIL %s: take=%0b vec=%0h cls=%0b expected take=%0b vec=%0h cls=%0b",
                  tag, take_o, vec_o, class_o, t, v, c);
      end
   endtask

   task automatic bnd_check(input string tag, input bit t, input bit [7:0] v, input bit [1:0] c);
      boundary_i = 1; tick(1); clr();
      expect_take(tag, t, v, c);
      tick(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1; fails++; checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      fault_vec_i = 8'h0D; swi_vec_i = 8'h80; intr_vec_i = 8'h41;
      cur_req = "R1";
      tick(3);
      rst_n = 1; tick(2);

      // R2: requests without a boundary are ignored
      cur_req = "R2";
      fault_req_i = 1; tick(3); fault_req_i = 0; tick(1);
      expect_take("R2", 0, 0, 0);
      fault_req_i = 1; bnd_check("R2", 1, 8'h0D, 2'b01);
      expect_take("R2", 0, 0, 0);

      // R4: each source alone
      cur_req = "R4";
      dbg_fault_i = 1; bnd_check("R4", 1, 8'h01, 2'b01);
      swi_req_i = 1;   bnd_check("R4", 1, 8'h80, 2'b10);
      dbg_trap_i = 1;  bnd_check("R4", 1, 8'h01, 2'b10);
      if_flag_i = 1; intr_i = 1; bnd_check("R4", 1, 8'h41, 2'b11); intr_i = 0;
      nmi_i = 1; tick(1); nmi_i = 0; tick(1);
      bnd_check("R4", 1, 8'h02, 2'b11);
      iret_i = 1; tick(1); iret_i = 0; tick(1);

      // R3: priority cascade with everything asserted
      cur_req = "R3";
      intr_i = 1; nmi_i = 1; tick(1); nmi_i = 0; tick(1);
      dbg_fault_i = 1; fault_req_i = 1; swi_req_i = 1; dbg_trap_i = 1;
      bnd_check("R3", 1, 8'h01, 2'b01);
      fault_req_i = 1; swi_req_i = 1; dbg_trap_i = 1; bnd_check("R3", 1, 8'h0D, 2'b01);
      swi_req_i = 1; dbg_trap_i = 1;                  bnd_check("R3", 1, 8'h80, 2'b10);
      dbg_trap_i = 1;                                 bnd_check("R3", 1, 8'h01, 2'b10);
      cur_req = "R6";
      bnd_check("R6", 1, 8'h02, 2'b11);   // NMI survived four losses
      cur_req = "R3";
      bnd_check("R3", 1, 8'h41, 2'b11);
      intr_i = 0;
      iret_i = 1; tick(1); iret_i = 0; tick(1);

      // R5: losing exceptions are dropped
      cur_req = "R5";
      fault_req_i = 1; swi_req_i = 1; dbg_trap_i = 1; bnd_check("R5", 1, 8'h0D, 2'b01);
      bnd_check("R5", 0, 0, 0);

      // R6: NMI edge coincides with a fault at the boundary
      cur_req = "R6";
      nmi_i = 1; dbg_fault_i = 1; bnd_check("R6", 1, 8'h01, 2'b01);
      nmi_i = 0;
      bnd_check("R6", 1, 8'h02, 2'b11);

      // R8: blocked; two edges collapse to one; release by iret
      cur_req = "R8";
      repeat (2) begin
         nmi_i = 1; tick(1); nmi_i = 0; tick(1);
         bnd_check("R8", 0, 0, 0);
      end
      iret_i = 1; tick(1); iret_i = 0; tick(1);
      bnd_check("R8", 1, 8'h02, 2'b11);
      iret_i = 1; tick(1); iret_i = 0; tick(1);
      bnd_check("R8", 0, 0, 0);

      // R7: mask flag gates INTR only
      cur_req = "R7";
      if_flag_i = 0; intr_i = 1;
      bnd_check("R7", 0, 0, 0);
      nmi_i = 1; tick(1); nmi_i = 0; tick(1);
      bnd_check("R7", 1, 8'h02, 2'b11);
      if_flag_i = 1; intr_vec_i = 8'hF3;
      bnd_check("R7", 1, 8'hF3, 2'b11);
      intr_i = 0;
      iret_i = 1; tick(1); iret_i = 0; tick(1);

      // R9: pin held high gives one delivery
      cur_req = "R9";
      nmi_i = 1; tick(2);
      bnd_check("R9", 1, 8'h02, 2'b11);
      iret_i = 1; tick(1); iret_i = 0; tick(1);
      bnd_check("R9", 0, 0, 0);
      nmi_i = 0; tick(1);

      // R10: INTR pulse released before the boundary is lost
      cur_req = "R10";
      intr_i = 1; tick(2); intr_i = 0; tick(1);
      bnd_check("R10", 0, 0, 0);

      // randomised mix, compared by the model every clock
      cur_req = "R3";
      for (int k = 0; k < 3000; k++) begin
         boundary_i  = ($urandom_range(0, 2) == 0);
         dbg_fault_i = ($urandom_range(0, 15) == 0);
         fault_req_i = ($urandom_range(0, 7) == 0);
         swi_req_i   = ($urandom_range(0, 7) == 0);
         dbg_trap_i  = ($urandom_range(0, 7) == 0);
         nmi_i       = ($urandom_range(0, 5) == 0);
         intr_i      = ($urandom_range(0, 2) == 0);
         if_flag_i   = ($urandom_range(0, 1) == 0);
         iret_i      = ($urandom_range(0, 9) == 0);
         fault_vec_i = 8'($urandom);
         swi_vec_i   = 8'($urandom);
         intr_vec_i  = 8'($urandom);
         tick(1);
      end
      clr(); nmi_i = 0; intr_i = 0;
      tick(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule